// File: doc/BRIEF.md
# Integer Execution Unit with Condition Flags

This block is the integer datapath stage of a small RISC core. It is purely combinational: given an operation code, the two register operands, a 5-bit and a 16-bit immediate, a 4-bit condition selector and the current flag word, it produces a 32-bit result and a write-enable for the destination register. It also produces the next flag word together with a mask of the flags the operation wrote.

The operations are:

- add, in register and 5-bit-immediate form;
- add of a 16-bit immediate;
- bitwise AND, in register form and with a 16-bit immediate;
- compare, in register and 5-bit-immediate form;
- two byte-reordering operations;
- conditional move, with a register or a 5-bit immediate as the taken value.

Operand `src_a` plays the role of the first source register. Operand `src_b` is the second source and, for most operations, also the old value of the destination. The caller writes `result` back when `wr_en` is high and loads `flags_out` into its flag register unconditionally. Flags that the operation does not touch pass through `flags_out` unchanged from `flags_in`. Flag bit order everywhere is [3]=CY, [2]=OV, [1]=S, [0]=Z.

Top module: `int_exec_unit`

## Requirements
- R1: Op 0 gives src_b + src_a. Op 1 gives src_b + sign-extended imm5. Both assert wr_en.
- R2: Op 2 gives src_a + sign-extended imm16 and asserts wr_en.
- R3: For ops 0, 1, 2, 5 and 6 all four flags are written (mask 4'b1111). S is result bit 31 and Z is set when the result is zero. For adds, CY is the carry out of bit 31 and OV is signed overflow.
- R4: Op 3 gives src_b AND src_a with wr_en high. OV is cleared, S and Z follow the result, CY keeps its flags_in value, and the mask is 4'b0111.
- R5: Op 4 gives src_a AND zero-extended imm16 with wr_en high. OV and S are cleared, Z follows the result, CY keeps its flags_in value, and the mask is 4'b0111.
- R6: Op 5 computes src_b − src_a and op 6 computes src_b − sign-extended imm5. The difference appears on result with wr_en low. CY is the borrow and OV is signed overflow.
- R7: Op 7 (swap within halfwords) gives bytes src_b[23:16], [31:24], [7:0], [15:8], from most to least significant.
- R8: Op 8 (full byte reversal) gives src_b[7:0], [15:8], [23:16], [31:24], from most to least significant.
- R9: For ops 7 and 8 all four flags are written. OV is 0, CY is set when any byte of the result is zero, S is result bit 31, and Z is set when the result is zero.
- R10: Op 9 gives src_a when the condition holds and src_b otherwise. Op 10 gives sign-extended imm5 when it holds and src_b otherwise. Both assert wr_en, have mask 0, and return flags_out equal to flags_in.
- R11: Condition codes 0 to 7 are: OV, CY, Z, CY|Z, S, always, S^OV, (S^OV)|Z. Codes 8 to 15 are the inverses of codes 0 to 7.
- R12: Op codes 11 to 15 give result 0, wr_en 0, mask 0 and flags_out equal to flags_in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 4 | Operation selector (encodings in R1 to R12) |
| src_a | input | 32 | First source register value |
| src_b | input | 32 | Second source / old destination value |
| imm5 | input | 5 | Short immediate, sign-extended where used |
| imm16 | input | 16 | Long immediate, sign- or zero-extended by operation |
| cond_code | input | 4 | Condition selector for conditional move |
| flags_in | input | 4 | Current flags {CY,OV,S,Z} |
| result | output | 32 | Operation result |
| wr_en | output | 1 | Destination register write-enable |
| flags_out | output | 4 | Next flag word {CY,OV,S,Z} |
| flags_mask | output | 4 | Flags written by this operation |

## Verification
The hardest situations to reach are the flag corners: a carry without a signed overflow and the reverse, a borrow across the sign boundary, and a byte swap whose result contains a zero byte without being zero overall. Directed operands are used to reach these, such as 0x7FFFFFFF+1, 0xFFFFFFFF+1, 0x80000000 minus 1, and words with a single zero byte. The condition table is covered by running conditional move for every one of the 16 codes against every one of the 16 flag combinations, in both operand forms.

// File: rtl/iex_pkg.sv
package iex_pkg;

    localparam int XLEN_DEFAULT = 32;

    typedef enum logic [3:0] {
        OP_ADD_R    = 4'd0,
        OP_ADD_I5   = 4'd1,
        OP_ADD_I16  = 4'd2,
        OP_AND_R    = 4'd3,
        OP_AND_I16  = 4'd4,
        OP_CMP_R    = 4'd5,
        OP_CMP_I5   = 4'd6,
        OP_SWAP_HW  = 4'd7,
        OP_SWAP_W   = 4'd8,
        OP_CMOV_R   = 4'd9,
        OP_CMOV_I5  = 4'd10
    } iex_op_e;

    typedef struct packed {
        logic cy;
        logic ov;
        logic s;
        logic z;
    } iex_flags_t;

    // Evaluate a 4-bit condition against the flag word; bit 3 inverts.
    function automatic logic cond_true(input logic [3:0] cc, input iex_flags_t f);
        logic base;
        case (cc[2:0])
            3'd0:    base = f.ov;
            3'd1:    base = f.cy;
            3'd2:    base = f.z;
            3'd3:    base = f.cy | f.z;
            3'd4:    base = f.s;
            3'd5:    base = 1'b1;
            3'd6:    base = f.s ^ f.ov;
            default: base = (f.s ^ f.ov) | f.z;
        endcase
        return base ^ cc[3];
    endfunction

endpackage

// File: rtl/iex_addsub.sv
module iex_addsub #(
    parameter int W = 32
) (
    input  logic         sub,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic [W-1:0] sum,
    output logic         carry,
    output logic         ovf
);
    localparam int MSB = W - 1;

    logic [W-1:0] opb_eff;
    logic [W:0]   wide;

    always_comb begin
        opb_eff = sub ? ~opb : opb;
        wide    = {1'b0, opa} + {1'b0, opb_eff} + {{W{1'b0}}, sub};
        sum     = wide[W-1:0];
        // Subtraction reports a borrow, the inverse of the adder's carry.
        carry   = sub ? ~wide[W] : wide[W];
        ovf     = (opa[MSB] == opb_eff[MSB]) && (sum[MSB] != opa[MSB]);
    end
endmodule

// File: rtl/iex_byteswap.sv
module iex_byteswap #(
    parameter int W = 32
) (
    input  logic         whole_word,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         any_zero_byte
);
    localparam int NB = W / 8;

    logic [W-1:0] rev_w;
    logic [W-1:0] rev_h;

    genvar gi;
    generate
        for (gi = 0; gi < NB; gi++) begin : g_byte
            assign rev_w[gi*8 +: 8] = din[(NB-1-gi)*8 +: 8];
            assign rev_h[gi*8 +: 8] = din[(gi ^ 1)*8 +: 8];
        end
    endgenerate

    always_comb begin
        dout          = whole_word ? rev_w : rev_h;
        any_zero_byte = 1'b0;
        for (int b = 0; b < NB; b++) begin
            if (dout[b*8 +: 8] == 8'h00) any_zero_byte = 1'b1;
        end
    end
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
    import iex_pkg::*;
#(
    parameter int XLEN = XLEN_DEFAULT
) (
    input  logic [3:0]      op_code,
    input  logic [XLEN-1:0] src_a,
    input  logic [XLEN-1:0] src_b,
    input  logic [4:0]      imm5,
    input  logic [15:0]     imm16,
    input  logic [3:0]      cond_code,
    input  logic [3:0]      flags_in,
    output logic [XLEN-1:0] result,
    output logic            wr_en,
    output logic [3:0]      flags_out,
    output logic [3:0]      flags_mask
);
    localparam int MSB = XLEN - 1;

    iex_op_e    op;
    iex_flags_t fin;
    iex_flags_t fnew;

    logic [XLEN-1:0] sx5, sx16, zx16;
    logic [XLEN-1:0] as_a, as_b, as_sum, sw_out;
    logic            as_sub, as_cy, as_ov, sw_zb, cond_ok, res_zero;

    assign op   = iex_op_e'(op_code);
    assign fin  = iex_flags_t'(flags_in);
    assign sx5  = {{(XLEN-5){imm5[4]}}, imm5};
    assign sx16 = {{(XLEN-16){imm16[15]}}, imm16};
    assign zx16 = {{(XLEN-16){1'b0}}, imm16};

    // Operand steering for the shared adder/subtractor.
    always_comb begin
        as_a   = src_b;
        as_b   = src_a;
        as_sub = 1'b0;
        case (op)
            OP_ADD_I5:  as_b = sx5;
            OP_ADD_I16: begin as_a = src_a; as_b = sx16; end
            OP_CMP_R:   as_sub = 1'b1;
            OP_CMP_I5:  begin as_b = sx5; as_sub = 1'b1; end
            default:    ;
        endcase
    end

    iex_addsub #(.W(XLEN)) u_addsub (
        .sub   (as_sub),
        .opa   (as_a),
        .opb   (as_b),
        .sum   (as_sum),
        .carry (as_cy),
        .ovf   (as_ov)
    );

    iex_byteswap #(.W(XLEN)) u_swap (
        .whole_word    (op == OP_SWAP_W),
        .din           (src_b),
        .dout          (sw_out),
        .any_zero_byte (sw_zb)
    );

    assign cond_ok = cond_true(cond_code, fin);

    // Result and write-enable selection.
    always_comb begin
        result = '0;
        wr_en  = 1'b0;
        case (op)
            OP_ADD_R, OP_ADD_I5, OP_ADD_I16: begin result = as_sum; wr_en = 1'b1; end
            OP_CMP_R, OP_CMP_I5:             result = as_sum;
            OP_AND_R:                        begin result = src_b & src_a; wr_en = 1'b1; end
            OP_AND_I16:                      begin result = src_a & zx16;  wr_en = 1'b1; end
            OP_SWAP_HW, OP_SWAP_W:           begin result = sw_out; wr_en = 1'b1; end
            OP_CMOV_R:                       begin result = cond_ok ? src_a : src_b; wr_en = 1'b1; end
            OP_CMOV_I5:                      begin result = cond_ok ? sx5   : src_b; wr_en = 1'b1; end
            default:                         ;
        endcase
    end

    assign res_zero = (result == '0);

    // Flag computation and merge with the incoming flag word.
    always_comb begin
        fnew       = fin;
        flags_mask = 4'b0000;
        case (op)
            OP_ADD_R, OP_ADD_I5, OP_ADD_I16, OP_CMP_R, OP_CMP_I5: begin
                fnew       = '{cy: as_cy, ov: as_ov, s: result[MSB], z: res_zero};
                flags_mask = 4'b1111;
            end
            OP_AND_R: begin
                fnew.ov = 1'b0; fnew.s = result[MSB]; fnew.z = res_zero;
                flags_mask = 4'b0111;
            end
            OP_AND_I16: begin
                fnew.ov = 1'b0; fnew.s = 1'b0; fnew.z = res_zero;
                flags_mask = 4'b0111;
            end
            OP_SWAP_HW, OP_SWAP_W: begin
                fnew       = '{cy: sw_zb, ov: 1'b0, s: result[MSB], z: res_zero};
                flags_mask = 4'b1111;
            end
            default: ;
        endcase
        flags_out = fnew;
    end

    // Assertions guarding the flag and write-enable logic.
    always_comb begin
        if (flags_mask[0] && op != OP_CMOV_R && op != OP_CMOV_I5)
            p_zero_tracks_result_r3: assert (flags_out[0] == (result == '0))
                else $error("Z flag disagrees with result");
        if (op == OP_CMP_R || op == OP_CMP_I5)
            p_compare_no_write_r6: assert (!wr_en)
                else $error("compare asserted write-enable");
        if (op == OP_AND_I16)
            p_andi_sign_clear_r5: assert (!flags_out[1] && !flags_out[2] && flags_out[3] == flags_in[3])
                else $error("AND-immediate flag rule broken");
        if (op == OP_SWAP_HW || op == OP_SWAP_W)
            p_swap_ov_clear_r9: assert (!flags_out[2] && flags_mask == 4'b1111)
                else $error("byte swap flag rule broken");
        if (op == OP_CMOV_R || op == OP_CMOV_I5)
            p_cmov_flags_kept_r10: assert (flags_mask == 4'b0000 && flags_out == flags_in && wr_en)
                else $error("conditional move touched flags");
        if (op_code > 4'd10)
            p_undef_inert_r12: assert (!wr_en && flags_mask == 4'b0000 && flags_out == flags_in)
                else $error("undefined op had an effect");
    end
endmodule

// File: tb/int_exec_unit_test.sv
module int_exec_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  op_code;
    logic [31:0] src_a, src_b;
    logic [4:0]  imm5;
    logic [15:0] imm16;
    logic [3:0]  cond_code, flags_in;
    logic [31:0] result;
    logic        wr_en;
    logic [3:0]  flags_out, flags_mask;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    int_exec_unit uut (
        .op_code(op_code), .src_a(src_a), .src_b(src_b), .imm5(imm5), .imm16(imm16),
        .cond_code(cond_code), .flags_in(flags_in), .result(result), .wr_en(wr_en),
        .flags_out(flags_out), .flags_mask(flags_mask)
    );

    function automatic logic ref_cond(input logic [3:0] cc, input logic [3:0] f);
        logic c, v, s, z, b;
        {c, v, s, z} = f;
        case (cc & 4'h7)
            0: b = v;   1: b = c;   2: b = z;   3: b = c | z;
            4: b = s;   5: b = 1;   6: b = s ^ v; default: b = (s ^ v) | z;
        endcase
        return cc[3] ? !b : b;
    endfunction

    task automatic expect_vec(input string req, input logic [3:0] op, input logic [31:0] a, b,
                              input logic [4:0] i5, input logic [15:0] i16,
                              input logic [3:0] cc, fi);
        logic [31:0] er, s5, s16, y;
        logic [32:0] w;
        logic ew, c, v;
        logic [3:0] ef, em;
        s5  = {{27{i5[4]}}, i5};
        s16 = {{16{i16[15]}}, i16};
        er = 0; ew = 0; ef = fi; em = 0;
        if (op <= 2) begin
            y = (op == 2) ? s16 : (op == 1 ? s5 : a);
            w = (op == 2) ? {1'b0, a} + {1'b0, y} : {1'b0, b} + {1'b0, y};
            er = w[31:0]; ew = 1; em = 4'hF;
            c = w[32];
            v = (op == 2) ? (a[31] == y[31] && er[31] != a[31]) : (b[31] == y[31] && er[31] != b[31]);
            ef = {c, v, er[31], er == 0};
        end else if (op == 5 || op == 6) begin
            y = (op == 6) ? s5 : a;
            er = b - y; em = 4'hF;
            c = b < y;
            v = (b[31] != y[31]) && (er[31] != b[31]);
            ef = {c, v, er[31], er == 0};
        end else if (op == 3) begin
            er = a & b; ew = 1; em = 4'h7; ef = {fi[3], 1'b0, er[31], er == 0};
        end else if (op == 4) begin
            er = a & {16'h0, i16}; ew = 1; em = 4'h7; ef = {fi[3], 2'b00, er == 0};
        end else if (op == 7 || op == 8) begin
            er = (op == 7) ? {b[23:16], b[31:24], b[7:0], b[15:8]}
                           : {b[7:0], b[15:8], b[23:16], b[31:24]};
            ew = 1; em = 4'hF;
            c = (er[31:24] == 0) || (er[23:16] == 0) || (er[15:8] == 0) || (er[7:0] == 0);
            ef = {c, 1'b0, er[31], er == 0};
        end else if (op == 9 || op == 10) begin
            er = ref_cond(cc, fi) ? (op == 10 ? s5 : a) : b; ew = 1;
        end
        @(negedge clk);
        op_code = op; src_a = a; src_b = b; imm5 = i5; imm16 = i16; cond_code = cc; flags_in = fi;
        #1;
        checks++;
        if (result !== er || wr_en !== ew || flags_out !== ef || flags_mask !== em) begin
            failures++;
            $display("FAIL %s op=%0d: result=%h wr=%b flags=%b mask=%b, expected result=%h wr=%b flags=%b mask=%b",
                     req, op, result, wr_en, flags_out, flags_mask, er, ew, ef, em);
        end
    endtask

    task automatic t_idle;   // reset-state / all-zero inputs: add of zeros, Z set (R3)
        expect_vec("R3 idle", 0, 0, 0, 0, 0, 0, 4'h0);
    endtask

    task automatic t_add;
        expect_vec("R1 add reg", 0, 32'h0000_0005, 32'h0000_0007, 0, 0, 0, 4'h0);
        expect_vec("R1 add imm5 negative", 1, 0, 32'h0000_0010, 5'h1F, 0, 0, 4'h0);
        expect_vec("R3 carry no overflow", 0, 32'h0000_0001, 32'hFFFF_FFFF, 0, 0, 0, 4'h0);
        expect_vec("R3 overflow no carry", 0, 32'h0000_0001, 32'h7FFF_FFFF, 0, 0, 0, 4'h0);
        expect_vec("R3 carry and overflow", 0, 32'h8000_0000, 32'h8000_0000, 0, 0, 0, 4'hF);
        expect_vec("R2 addi negative", 2, 32'h0000_1000, 32'hDEAD_BEEF, 0, 16'h8000, 0, 4'h0);
        expect_vec("R2 addi positive", 2, 32'h7FFF_0000, 32'h0, 0, 16'hFFFF, 0, 4'h5);
    endtask

    task automatic t_and;
        expect_vec("R4 and cy kept 1", 3, 32'hF0F0_F0F0, 32'hFF00_FF00, 0, 0, 0, 4'hC);
        expect_vec("R4 and zero cy kept 0", 3, 32'h0F0F_0F0F, 32'hF0F0_F0F0, 0, 0, 0, 4'h7);
        expect_vec("R5 andi zero-extend", 4, 32'hFFFF_FFFF, 0, 0, 16'h8001, 0, 4'hE);
        expect_vec("R5 andi zero result", 4, 32'hFFFF_0000, 0, 0, 16'hFFFF, 0, 4'h6);
    endtask

    task automatic t_cmp;
        expect_vec("R6 cmp equal", 5, 32'h1234_5678, 32'h1234_5678, 0, 0, 0, 4'h0);
        expect_vec("R6 cmp borrow", 5, 32'h0000_0002, 32'h0000_0001, 0, 0, 0, 4'h0);
        expect_vec("R6 cmp signed overflow", 5, 32'h0000_0001, 32'h8000_0000, 0, 0, 0, 4'h0);
        expect_vec("R6 cmp imm5 negative", 6, 0, 32'hFFFF_FFF0, 5'h10, 0, 0, 4'hF);
        expect_vec("R6 cmp imm5 borrow", 6, 0, 32'h0000_0003, 5'h07, 0, 0, 4'h0);
    endtask

    task automatic t_swap;
        expect_vec("R7 halfword swap", 7, 0, 32'h1122_3344, 0, 0, 0, 4'h0);
        expect_vec("R8 word swap", 8, 0, 32'h1122_3344, 0, 0, 0, 4'h0);
        expect_vec("R9 swap zero byte", 7, 0, 32'h8100_4455, 0, 0, 0, 4'h0);
        expect_vec("R9 swap sign", 8, 0, 32'h0102_0380, 0, 0, 0, 4'h0);
        expect_vec("R9 swap all zero", 8, 0, 32'h0, 0, 0, 0, 4'h4);
    endtask

    task automatic t_cmov;   // R10 and R11: every code against every flag combination
        for (int cc = 0; cc < 16; cc++) begin
            for (int f = 0; f < 16; f++) begin
                expect_vec("R11 cmov reg", 9, 32'hAAAA_0001, 32'h5555_0002, 0, 0, cc[3:0], f[3:0]);
                expect_vec("R10 cmov imm5", 10, 32'h0, 32'h0000_1234, 5'h13, 0, cc[3:0], f[3:0]);
            end
        end
    endtask

    task automatic t_undef;
        for (int op = 11; op < 16; op++)
            expect_vec("R12 undefined op", op[3:0], 32'hFFFF_FFFF, 32'h1, 5'h1F, 16'hFFFF, 4'h5, 4'hA);
    endtask

    initial begin
        op_code = 0; src_a = 0; src_b = 0; imm5 = 0; imm16 = 0; cond_code = 0; flags_in = 0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_idle();
        t_add();
        t_and();
        t_cmp();
        t_swap();
        t_cmov();
        t_undef();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            failures++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule